// File: doc/BRIEF.md
# I2C Serial Memory Slave Controller

This block is the two-wire bus front end of a 1K x 8 serial memory. A fast system clock oversamples the bus clock and data lines. The block finds start and stop conditions and checks the device select byte against a strap pin. It takes in the word address and runs byte write, page write, random read, current read and sequential read. It holds the 10-bit internal address register. Reads go through a synchronous memory read port with one cycle of latency. Each received write byte goes out as a strobe to a separate page-write sequencer. A commit pulse at the stop tells the sequencer to start its internal write cycle.

The data line is open-drain: the block drives only an output enable, which pulls the line low. While the sequencer reports an internal write cycle in progress, the block ignores select bytes and does not acknowledge them. This lets the master poll for the end of the write.

Top module: `i2cm_slave_ctrl`

## Requirements
- R1: A start is the data line falling while the clock line is high. A stop is the data line rising while the clock line is high. A start is recognised at any point and restarts the command from the select byte, so a partly received byte is dropped without a write strobe.
- R2: The select byte is received MSB first as type bits 7:4 = 1010, device bit 3, page bits 2:1 and direction bit 0 (0 = write, 1 = read). The block acknowledges only when the type is 1010 and the device bit equals `dev_pin_i`. Otherwise it leaves the line released until the next start or stop.
- R3: While `wr_busy_i` is high, a select byte is not acknowledged and the rest of the command is ignored.
- R4: In a write, the block pulls the data line low during the ninth clock after the select byte, after the word address and after each data byte. The address loaded is {page bits, word address byte}.
- R5: Each write data byte gives one single-cycle `wr_stb_o` pulse carrying the current address and the byte. The address then advances in its low 4 bits only, wrapping within a 16-byte page (for example 10Eh, 10Fh, 100h).
- R6: A stop after at least one data byte has been acknowledged pulses `wr_commit_o` once. A stop with no data byte gives no pulse.
- R7: Read bytes are sent MSB first. The output changes only after a clock fall and holds while the clock is high. The enable is asserted only for 0 bits and is released for 1 bits and in the master acknowledge slot.
- R8: A random read is a write select plus word address, then a restart with a read select. It returns the byte at the address that was set.
- R9: In a read, a master acknowledge (low) makes the block send the next byte. The address increments across 256-byte regions and wraps from 3FFh to 000h. A master not-acknowledge (high) ends the output, and the line stays released until a stop.
- R10: A current read returns the byte at the address register, which points one past the last address accessed. After a read it is the last read address plus 1. After a write it is the page-wrapped successor of the last written address.
- R11: After reset the output enable is low and no write strobe or commit pulse is given.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line, unsynchronised |
| sda_i | input | 1 | Bus data line as seen on the pad, unsynchronised |
| sda_oe_o | output | 1 | Pulls the data line low when high |
| dev_pin_i | input | 1 | Strap level compared with the device bit |
| wr_busy_i | input | 1 | Internal write cycle in progress |
| mem_rd_en_o | output | 1 | Memory read request |
| mem_rd_addr_o | output | ADDR_W | Memory read address |
| mem_rd_data_i | input | 8 | Read data, valid the cycle after the request |
| wr_stb_o | output | 1 | One write byte for the sequencer |
| wr_addr_o | output | ADDR_W | Address of the write byte |
| wr_data_o | output | 8 | Write byte |
| wr_commit_o | output | 1 | Start the internal write cycle |

## Verification
The assertions assume that the bus lines change only when no clock edge falls within the synchroniser window. They also assume that the data line changes only while the clock is low, except for deliberate start and stop conditions. The bench drives every bus phase for several system clocks. It moves the master's data bit a quarter period after each clock fall, so every data and acknowledge change is well clear of the clock high phase. The bench's write sequencer model raises `wr_busy_i` only after a commit and drops it after a fixed count, so busy never changes in the middle of a select byte being checked.

// File: rtl/i2cm_pkg.sv
package i2cm_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RX,
    ST_ACK,
    ST_TX,
    ST_MACK,
    ST_SKIP
  } i2cm_state_e;

  typedef enum logic [1:0] {
    RX_SEL,
    RX_WADDR,
    RX_WDATA
  } i2cm_rx_e;

  localparam logic [3:0] DEV_TYPE = 4'b1010;

  // sequential read step: plain increment, wrap at the array size
  function automatic logic [15:0] step_linear(input logic [15:0] a, input logic [15:0] mask);
    return (a + 16'd1) & mask;
  endfunction

  // page write step: only the bits under pg_mask advance, the rest hold
  function automatic logic [15:0] step_in_page(input logic [15:0] a, input logic [15:0] pg_mask);
    return (a & ~pg_mask) | ((a + 16'd1) & pg_mask);
  endfunction

endpackage

// File: rtl/i2cm_line_sync.sv
module i2cm_line_sync #(
  parameter int STAGES = 2,
  parameter int LINES  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LINES-1:0] din,
  output logic [LINES-1:0] dout
);

  for (genvar g = 0; g < LINES; g++) begin : g_line
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '1;
      else        chain <= {chain[STAGES-2:0], din[g]};
    end
    assign dout[g] = chain[STAGES-1];
  end

endmodule

// File: rtl/i2cm_cond_detect.sv
module i2cm_cond_detect (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_s,
  input  logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic evt_start,
  output logic evt_stop
);

  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_s;
      sda_q <= sda_s;
    end
  end

  assign scl_rise  =  scl_s & ~scl_q;
  assign scl_fall  = ~scl_s &  scl_q;
  assign evt_start =  scl_s &  scl_q &  sda_q & ~sda_s;
  assign evt_stop  =  scl_s &  scl_q & ~sda_q &  sda_s;

endmodule

// File: rtl/i2cm_addr_reg.sv
module i2cm_addr_reg
  import i2cm_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int PG_W   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_en,
  input  logic [ADDR_W-1:0] load_val,
  input  logic              inc_rd,
  input  logic              inc_wr,
  output logic [ADDR_W-1:0] addr,
  output logic [ADDR_W-1:0] addr_nxt_rd
);

  localparam logic [15:0] A_MASK  = 16'((1 << ADDR_W) - 1);
  localparam logic [15:0] PG_MASK = 16'((1 << PG_W) - 1);

  logic [15:0] lin_w, pg_w;

  assign lin_w       = step_linear(16'(addr), A_MASK);
  assign pg_w        = step_in_page(16'(addr), PG_MASK);
  assign addr_nxt_rd = lin_w[ADDR_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       addr <= '0;
    else if (load_en) addr <= load_val;
    else if (inc_rd)  addr <= lin_w[ADDR_W-1:0];
    else if (inc_wr)  addr <= pg_w[ADDR_W-1:0];
  end

  // R5: page write stepping never leaves the page
  a_r5_page_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (inc_wr && !load_en) |=> (addr[ADDR_W-1:PG_W] == $past(addr[ADDR_W-1:PG_W])));

  // R9: read stepping is a plain increment modulo the array size
  a_r9_read_step: assert property (@(posedge clk) disable iff (!rst_n)
    (inc_rd && !load_en) |=> (addr == ADDR_W'($past(addr) + 1'b1)));

endmodule

// File: rtl/i2cm_slave_ctrl.sv
module i2cm_slave_ctrl
  import i2cm_pkg::*;
#(
  parameter int ADDR_W      = 10,
  parameter int PG_W        = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe_o,
  input  logic              dev_pin_i,
  input  logic              wr_busy_i,
  output logic              mem_rd_en_o,
  output logic [ADDR_W-1:0] mem_rd_addr_o,
  input  logic [7:0]        mem_rd_data_i,
  output logic              wr_stb_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [7:0]        wr_data_o,
  output logic              wr_commit_o
);

  localparam int SEL_W = ADDR_W - 8;

  logic [1:0] sync_out;
  logic scl_s, sda_s;
  logic scl_rise, scl_fall, evt_start, evt_stop;

  i2cm_line_sync #(.STAGES(SYNC_STAGES), .LINES(2)) u_sync (
    .clk (clk), .rst_n (rst_n),
    .din ({scl_i, sda_i}),
    .dout(sync_out)
  );
  assign scl_s = sync_out[1];
  assign sda_s = sync_out[0];

  i2cm_cond_detect u_cond (
    .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_s(sda_s),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .evt_start(evt_start), .evt_stop(evt_stop)
  );

  i2cm_state_e       state;
  i2cm_rx_e          rx_kind;
  logic [3:0]        cnt;
  logic [7:0]        shreg, txsh, txbuf;
  logic              rd_mode, mack_ok, wr_pend, rd_fill;
  logic [SEL_W-1:0]  page_q;
  logic [ADDR_W-1:0] addr, addr_nxt_rd;

  // named events shared with the assertions
  logic byte_eval, sel_eval, dev_hit, waddr_eval, wdata_eval;
  logic rd_issue_first, rd_issue_next;

  assign byte_eval      = (state == ST_RX) && scl_fall && (cnt == 4'd8);
  assign sel_eval       = byte_eval && (rx_kind == RX_SEL);
  assign waddr_eval     = byte_eval && (rx_kind == RX_WADDR);
  assign wdata_eval     = byte_eval && (rx_kind == RX_WDATA);
  assign dev_hit        = (shreg[7:4] == DEV_TYPE) && (shreg[3] == dev_pin_i) && !wr_busy_i;
  assign rd_issue_first = sel_eval && dev_hit && shreg[0];
  assign rd_issue_next  = (state == ST_TX) && scl_fall && (cnt == 4'd8);

  assign mem_rd_en_o   = rd_issue_first || rd_issue_next;
  assign mem_rd_addr_o = rd_issue_next ? addr_nxt_rd : addr;

  i2cm_addr_reg #(.ADDR_W(ADDR_W), .PG_W(PG_W)) u_addr (
    .clk(clk), .rst_n(rst_n),
    .load_en(waddr_eval), .load_val({page_q, shreg}),
    .inc_rd(rd_issue_next), .inc_wr(wdata_eval),
    .addr(addr), .addr_nxt_rd(addr_nxt_rd)
  );

  // prefetch buffer: read data arrives one cycle after the request
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_fill <= 1'b0;
      txbuf   <= '0;
    end else begin
      rd_fill <= mem_rd_en_o;
      if (rd_fill) txbuf <= mem_rd_data_i;
    end
  end

  // protocol sequencer
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      rx_kind  <= RX_SEL;
      cnt      <= '0;
      shreg    <= '0;
      txsh     <= '0;
      rd_mode  <= 1'b0;
      mack_ok  <= 1'b0;
      wr_pend  <= 1'b0;
      page_q   <= '0;
      sda_oe_o <= 1'b0;
    end else if (evt_start) begin
      state    <= ST_RX;
      rx_kind  <= RX_SEL;
      cnt      <= '0;
      sda_oe_o <= 1'b0;
      wr_pend  <= 1'b0;
    end else if (evt_stop) begin
      state    <= ST_IDLE;
      cnt      <= '0;
      sda_oe_o <= 1'b0;
      wr_pend  <= 1'b0;
    end else begin
      unique case (state)
        ST_RX: begin
          if (scl_rise) begin
            shreg <= {shreg[6:0], sda_s};
            cnt   <= cnt + 4'd1;
          end else if (byte_eval) begin
            cnt <= '0;
            unique case (rx_kind)
              RX_SEL: begin
                if (dev_hit) begin
                  sda_oe_o <= 1'b1;
                  state    <= ST_ACK;
                  rd_mode  <= shreg[0];
                  if (!shreg[0]) page_q <= shreg[SEL_W:1];
                end else begin
                  state <= ST_SKIP;
                end
              end
              RX_WADDR: begin
                sda_oe_o <= 1'b1;
                state    <= ST_ACK;
              end
              default: begin
                sda_oe_o <= 1'b1;
                state    <= ST_ACK;
                wr_pend  <= 1'b1;
              end
            endcase
          end
        end
        ST_ACK: begin
          if (scl_fall) begin
            if (rd_mode) begin
              state    <= ST_TX;
              sda_oe_o <= ~txbuf[7];
              txsh     <= {txbuf[6:0], 1'b0};
              cnt      <= 4'd1;
            end else begin
              state    <= ST_RX;
              sda_oe_o <= 1'b0;
              rx_kind  <= (rx_kind == RX_SEL) ? RX_WADDR : RX_WDATA;
            end
          end
        end
        ST_TX: begin
          if (scl_fall) begin
            if (cnt == 4'd8) begin
              sda_oe_o <= 1'b0;
              state    <= ST_MACK;
              cnt      <= '0;
            end else begin
              sda_oe_o <= ~txsh[7];
              txsh     <= {txsh[6:0], 1'b0};
              cnt      <= cnt + 4'd1;
            end
          end
        end
        ST_MACK: begin
          if (scl_rise) mack_ok <= ~sda_s;
          else if (scl_fall) begin
            if (mack_ok) begin
              state    <= ST_TX;
              sda_oe_o <= ~txbuf[7];
              txsh     <= {txbuf[6:0], 1'b0};
              cnt      <= 4'd1;
            end else begin
              state <= ST_SKIP;
            end
          end
        end
        default: ;
      endcase
    end
  end

  // sequencer side outputs
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_stb_o    <= 1'b0;
      wr_addr_o   <= '0;
      wr_data_o   <= '0;
      wr_commit_o <= 1'b0;
    end else begin
      wr_stb_o    <= wdata_eval;
      wr_commit_o <= evt_stop && wr_pend;
      if (wdata_eval) begin
        wr_addr_o <= addr;
        wr_data_o <= shreg;
      end
    end
  end

  // R1: a start always restarts byte reception with the line released
  a_r1_start_restarts: assert property (@(posedge clk) disable iff (!rst_n)
    evt_start |=> (state == ST_RX && cnt == 4'd0 && !sda_oe_o));

  // R2: a device bit that differs from the strap is never acknowledged
  a_r2_mismatch_nack: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_eval && (shreg[3] != dev_pin_i)) |=> !sda_oe_o);

  // R3: no acknowledge while the internal write cycle runs
  a_r3_busy_nack: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_eval && wr_busy_i) |=> !sda_oe_o);

  // R5: each write strobe lasts one cycle
  a_r5_stb_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb_o |=> !wr_stb_o);

  // R6: commit only follows a stop
  a_r6_commit_after_stop: assert property (@(posedge clk) disable iff (!rst_n)
    wr_commit_o |-> $past(evt_stop));

  // R7: the master acknowledge slot is never driven
  a_r7_release_mack: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_MACK) |-> !sda_oe_o);

endmodule

// File: tb/i2cm_slave_ctrl_tb_top.sv
module i2cm_slave_ctrl_tb_top;

  localparam int Q    = 6;
  localparam int BUSY = 500;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic scl_m = 1'b1, sda_m = 1'b1;
  logic dev_pin = 1'b1;
  logic sda_oe, mem_rd_en, wr_stb, wr_commit;
  logic [9:0] mem_rd_addr, wr_addr;
  logic [7:0] mem_rd_data, wr_data;
  logic wr_busy;
  wire  sda_line = sda_m & ~sda_oe;

  i2cm_slave_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
    .sda_oe_o(sda_oe), .dev_pin_i(dev_pin), .wr_busy_i(wr_busy),
    .mem_rd_en_o(mem_rd_en), .mem_rd_addr_o(mem_rd_addr), .mem_rd_data_i(mem_rd_data),
    .wr_stb_o(wr_stb), .wr_addr_o(wr_addr), .wr_data_o(wr_data), .wr_commit_o(wr_commit)
  );

  function automatic logic [7:0] pat(input int i);
    return 8'((i * 37) + ((i >> 8) * 11) + 5);
  endfunction

  // memory and write sequencer model
  logic [7:0] mem [0:1023];
  int busy_cnt = 0, stb_count = 0, commit_count = 0;
  logic [9:0] last_wa = '0;
  assign wr_busy = (busy_cnt != 0);

  initial for (int i = 0; i < 1024; i++) mem[i] = pat(i);

  always @(posedge clk) begin
    if (mem_rd_en) mem_rd_data <= mem[mem_rd_addr];
    if (wr_stb) begin
      mem[wr_addr] <= wr_data;
      stb_count    <= stb_count + 1;
      last_wa      <= wr_addr;
    end
    if (wr_commit) begin
      busy_cnt     <= BUSY;
      commit_count <= commit_count + 1;
    end else if (busy_cnt > 0) busy_cnt <= busy_cnt - 1;
  end

  int nchk = 0, nfail = 0, glitch = 0;

  task automatic chk(input string tag, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s: got %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    tick(1); sda_m = 1'b1; tick(Q); scl_m = 1'b1; tick(Q);
    sda_m = 1'b0; tick(Q); scl_m = 1'b0; tick(Q);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; tick(Q); scl_m = 1'b1; tick(Q); sda_m = 1'b1; tick(2 * Q);
  endtask

  task automatic bit_cycle(input logic b, output logic s);
    logic s1;
    sda_m = b; tick(Q); scl_m = 1'b1; tick(1); s1 = sda_line;
    tick(Q); s = sda_line;
    if (s1 != s) glitch++;
    tick(Q - 1); scl_m = 1'b0; tick(Q);
  endtask

  task automatic send_byte(input logic [7:0] v, output logic ack);
    logic s;
    for (int i = 7; i >= 0; i--) bit_cycle(v[i], s);
    bit_cycle(1'b1, s);
    ack = ~s;
  endtask

  task automatic recv_byte(input logic mack, output logic [7:0] v, output logic oe_slot);
    logic s;
    for (int i = 7; i >= 0; i--) begin
      bit_cycle(1'b1, s);
      v[i] = s;
    end
    sda_m = ~mack; tick(Q); scl_m = 1'b1; tick(Q); oe_slot = sda_oe;
    tick(Q); scl_m = 1'b0; tick(Q); sda_m = 1'b1;
  endtask

  function automatic logic [7:0] sel(input logic dev, input logic [1:0] pg, input logic rd);
    return {4'b1010, dev, pg, rd};
  endfunction

  // set address with a dummy write, restart as read, return first byte
  task automatic random_read_setup(input logic [9:0] a, output logic ok);
    logic k1, k2, k3;
    bus_start(); send_byte(sel(1'b1, a[9:8], 1'b0), k1); send_byte(a[7:0], k2);
    bus_start(); send_byte(sel(1'b1, a[9:8], 1'b1), k3);
    ok = k1 & k2 & k3;
  endtask

  task automatic wait_idle();
    logic k;
    for (int t = 0; t < 20; t++) begin
      bus_start(); send_byte(sel(1'b1, 2'b00, 1'b0), k); bus_stop();
      if (k) break;
    end
  endtask

  task automatic t_reset();
    chk("R11 oe after reset", int'(sda_oe), 0);
    chk("R11 strobe after reset", int'(wr_stb) + int'(wr_commit), 0);
  endtask

  task automatic t_page_write();
    logic k1, k2, k3, k4, k5;
    int s0 = stb_count, c0 = commit_count;
    bus_start(); send_byte(sel(1'b1, 2'b01, 1'b0), k1); send_byte(8'h0E, k2);
    send_byte(8'hA1, k3); send_byte(8'h3C, k4); send_byte(8'hC5, k5);
    chk("R4 acks on select/address/data", int'({k1, k2, k3, k4, k5}), 5'h1F);
    chk("R5 three strobes", stb_count - s0, 3);
    chk("R5 page wrap to 100h", int'(last_wa), 10'h100);
    bus_stop(); tick(2);
    chk("R6 one commit", commit_count - c0, 1);
  endtask

  task automatic t_ack_poll();
    logic k;
    int s0 = stb_count;
    bus_start(); send_byte(sel(1'b1, 2'b00, 1'b0), k);
    chk("R3 busy select nacked", int'(k), 0);
    send_byte(8'h55, k); send_byte(8'h99, k);
    chk("R3 busy command ignored", stb_count - s0, 0);
    bus_stop();
    wait_idle();
    chk("R3 acked after busy ends", int'(wr_busy), 0);
  endtask

  task automatic t_random_read();
    logic ok, oe;
    logic [7:0] v;
    int c0 = commit_count;
    random_read_setup(10'h10E, ok);
    recv_byte(1'b0, v, oe);
    bus_stop(); tick(2);
    chk("R8 random read acks", int'(ok), 1);
    chk("R8 random read 10Eh", int'(v), 8'hA1);
    chk("R6 no data no commit", commit_count - c0, 0);
    bus_start(); send_byte(sel(1'b1, 2'b00, 1'b1), ok);
    recv_byte(1'b0, v, oe); bus_stop();
    chk("R10 current read after read", int'(v), 8'h3C);
  endtask

  task automatic t_write_then_current();
    logic k;
    logic [7:0] v;
    logic oe;
    bus_start(); send_byte(sel(1'b1, 2'b10, 1'b0), k); send_byte(8'h3F, k);
    send_byte(8'h77, k); bus_stop();
    wait_idle();
    random_read_setup(10'h23F, k); recv_byte(1'b0, v, oe); bus_stop();
    chk("R5 byte written at 23Fh", int'(v), 8'h77);
    // write again to 23Fh; next address wraps to 230h inside the page
    bus_start(); send_byte(sel(1'b1, 2'b10, 1'b0), k); send_byte(8'h3F, k);
    send_byte(8'h78, k); bus_stop();
    wait_idle();
    bus_start(); send_byte(sel(1'b1, 2'b00, 1'b1), k); recv_byte(1'b0, v, oe); bus_stop();
    chk("R10 current read after write", int'(v), int'(pat(10'h230)));
  endtask

  task automatic t_seq_read();
    logic ok, oe, s;
    logic [7:0] v;
    int bad = 0, oe_bad = 0;
    random_read_setup(10'h3FE, ok);
    for (int i = 0; i < 4; i++) begin
      recv_byte(i != 3, v, oe);
      if (v != mem[(10'h3FE + i) % 1024]) bad++;
      if (oe) oe_bad++;
    end
    chk("R9 sequential wrap 3FEh..001h", bad, 0);
    chk("R7 master slot released", oe_bad, 0);
    bad = 0;
    for (int i = 0; i < 3; i++) begin
      bit_cycle(1'b1, s);
      if (!s) bad++;
    end
    chk("R9 line released after nack", bad, 0);
    bus_stop();
    random_read_setup(10'h0FF, ok);
    recv_byte(1'b1, v, oe);
    chk("R9 read at 0FFh", int'(v), int'(pat(10'h0FF)));
    recv_byte(1'b0, v, oe);
    chk("R9 cross into 100h region", int'(v), 8'hC5);
    bus_stop();
    chk("R7 output stable while clock high", glitch, 0);
  endtask

  task automatic t_wrong_device();
    logic k1, k2, k3;
    int s0 = stb_count;
    bus_start(); send_byte(sel(1'b0, 2'b00, 1'b0), k1); send_byte(8'h10, k2); send_byte(8'hEE, k3);
    bus_stop();
    chk("R2 device bit mismatch nacked", int'({k1, k2, k3}), 0);
    bus_start(); send_byte(8'b1011_1000, k1); send_byte(8'h10, k2); bus_stop();
    chk("R2 wrong type nacked", int'({k1, k2}), 0);
    chk("R2 no strobe", stb_count - s0, 0);
  endtask

  task automatic t_restart_mid();
    logic ok, oe, s;
    logic [7:0] v;
    int s0 = stb_count;
    bus_start();
    for (int i = 0; i < 4; i++) bit_cycle(1'b1, s);
    random_read_setup(10'h005, ok);
    recv_byte(1'b0, v, oe); bus_stop();
    chk("R1 restart inside select byte", int'(v), int'(pat(10'h005)));
    bus_start(); send_byte(sel(1'b1, 2'b00, 1'b0), ok); send_byte(8'h20, ok);
    for (int i = 0; i < 5; i++) bit_cycle(1'b0, s);
    bus_start(); bus_stop(); tick(2);
    chk("R1 partial byte dropped", stb_count - s0, 0);
    random_read_setup(10'h020, ok); recv_byte(1'b0, v, oe); bus_stop();
    chk("R1 memory untouched", int'(v), int'(pat(10'h020)));
  endtask

  initial begin
    tick(4); rst_n = 1'b1; tick(4);
    t_reset();
    t_page_write();
    t_ack_poll();
    t_random_read();
    t_write_then_current();
    t_seq_read();
    t_wrong_device();
    t_restart_mid();
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

endmodule